// File: doc/BRIEF.md
# UART Receiver with Multiprocessor Address Filter

This block is an asynchronous serial receiver for buses on which one master talks to many slaves over a shared line. It takes the raw RX line together with an external oversampling strobe that pulses sixteen times per bit period. It recovers frames made of one start bit, eight or nine data bits sent least significant bit first, and one stop bit. Each accepted frame is held in a one-entry receive buffer, and a ready flag signals it until a read strobe takes it.

In nine-bit mode an address filter can be switched on. While the filter is on, a frame is delivered only if its ninth bit is 1, which marks it as an address. Frames whose ninth bit is 0 are data frames; they are dropped without trace and the next frame overwrites them in the shift register. Firmware uses this as follows. It keeps the filter on until it sees its own address, then turns the filter off so that the data frames that follow also arrive. With the filter off, the ninth bit of every frame is passed to the readout unchanged, so software can use it as a parity bit.

Top module: `uart_addr_rx`

## Requirements
- R1: In eight-bit mode (`mode9_i`=0), each frame delivers its eight data bits, received LSB first, to `rx_data_o`. It also sets `rx_ready_o`, and `rx_bit9_o` reads 0.
- R2: In nine-bit mode (`mode9_i`=1), nine data bits are received per frame. Bits 0 to 7 go to `rx_data_o` and the ninth received bit goes to `rx_bit9_o`.
- R3: With `mode9_i`=1 and `addr_det_i`=1, a frame whose ninth bit is 0 leaves `rx_ready_o`, `rx_data_o` and `rx_bit9_o` unchanged.
- R4: With `mode9_i`=1 and `addr_det_i`=1, a frame whose ninth bit is 1 is delivered and sets `rx_ready_o`.
- R5: `addr_det_i` has no effect in eight-bit mode; every frame is delivered.
- R6: With `mode9_i`=1 and `addr_det_i`=0, every frame is delivered, whatever its ninth bit, and that bit appears unchanged on `rx_bit9_o`.
- R7: A falling edge on the RX line starts a frame only if the line is still low at the middle of the start bit. A low pulse shorter than half a bit produces no frame.
- R8: Each bit takes the majority of three samples, taken on oversampling ticks 7, 8 and 9 of the bit. A single corrupted sample does not change the received bit.
- R9: A stop bit that samples low sets `frame_err_o` together with the delivery of that frame. The next delivered frame with a good stop bit clears it.
- R10: A one-cycle pulse on `rd_i` clears `rx_ready_o` on the next clock edge.
- R11: If a frame is due for delivery while `rx_ready_o` is set and not being read, `overrun_o` is set and the frame is discarded. While `overrun_o` is set, no frame is delivered, even after a read. Driving `rx_en_i` low clears `overrun_o`.
- R12: While `rx_en_i` is low, activity on the RX line delivers nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling strobe, 16 per bit |
| rx_en_i | input | 1 | Receive enable |
| mode9_i | input | 1 | Nine-bit frame mode |
| addr_det_i | input | 1 | Address filter enable (nine-bit mode only) |
| rd_i | input | 1 | Read strobe, takes the buffered frame |
| rx_data_o | output | 8 | Buffered data byte |
| rx_bit9_o | output | 1 | Buffered ninth bit |
| rx_ready_o | output | 1 | Frame waiting in the buffer |
| frame_err_o | output | 1 | Stop-bit error of the buffered frame |
| overrun_o | output | 1 | Overrun latched |

## Verification
Two cases are the hardest to reach from the ports. The first is the blocked state after an overrun, where a read has already emptied the buffer but deliveries must still be held back. The bench gets there by sending two frames back to back without a read, then reading, then sending a third frame and checking that it does not arrive. It then pulses the enable low and shows that a fourth frame arrives. The second case is a majority vote that must mask a corrupted sample. The bench reaches it by inverting the line for exactly one clock, placed on the middle sample point of a chosen data bit, with the tick strobe held high so that the sample positions fall on known clock edges.

// File: rtl/uart_addr_rx_pkg.sv
package uart_addr_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_addr_rx_sync.sv
module uart_addr_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic line_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], rx_i};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_o = s_q.chain[STAGES-1];
    assign fall_o = s_q.prev & ~s_q.chain[STAGES-1];
endmodule

// File: rtl/uart_addr_rx_frame.sv
module uart_addr_rx_frame
    import uart_addr_rx_pkg::*;
#(
    parameter int unsigned OVS    = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              mode9_i,
    input  logic              line_i,
    input  logic              fall_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              bit9_o,
    output logic              ferr_o,
    output logic              mode9_o
);
    localparam int unsigned CNT_W = $clog2(OVS);
    localparam int unsigned FR_W  = DATA_W + 1;
    localparam int unsigned IDX_W = $clog2(FR_W + 1);
    localparam int unsigned MID   = OVS / 2;

    typedef struct packed {
        rx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [1:0]       smp;
        logic [FR_W-1:0]  sh;
        logic             m9;
        logic             ferr;
    } frm_t;

    frm_t f_d, f_q;
    logic vote;
    logic [IDX_W-1:0] nbits;

    always_comb begin
        f_d     = f_q;
        valid_o = 1'b0;
        vote    = maj3(f_q.smp[1], f_q.smp[0], line_i);
        nbits   = f_q.m9 ? IDX_W'(FR_W) : IDX_W'(DATA_W);
        if (!en_i) begin
            f_d.st  = ST_IDLE;
            f_d.cnt = '0;
        end else if (f_q.st == ST_IDLE) begin
            if (fall_i) begin
                f_d.st  = ST_START;
                f_d.cnt = '0;
                f_d.idx = '0;
                f_d.m9  = mode9_i;
            end
        end else if (tick_i) begin
            f_d.cnt = f_q.cnt + 1'b1;
            if (f_q.cnt == CNT_W'(MID - 2) || f_q.cnt == CNT_W'(MID - 1)) begin
                f_d.smp = {f_q.smp[0], line_i};
            end
            if (f_q.cnt == CNT_W'(MID)) begin
                case (f_q.st)
                    ST_START: if (vote) f_d.st = ST_IDLE;
                    ST_DATA: begin
                        f_d.sh  = {vote, f_q.sh[FR_W-1:1]};
                        f_d.idx = f_q.idx + 1'b1;
                    end
                    ST_STOP: begin
                        valid_o  = 1'b1;
                        f_d.ferr = ~vote;
                        f_d.st   = ST_IDLE;
                    end
                    default: f_d.st = ST_IDLE;
                endcase
            end
            if (f_q.cnt == CNT_W'(OVS - 1)) begin
                f_d.cnt = '0;
                if (f_q.st == ST_START) begin
                    f_d.st = ST_DATA;
                end else if (f_q.st == ST_DATA && f_q.idx == nbits) begin
                    f_d.st = ST_STOP;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q    <= '0;
            f_q.st <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign data_o  = f_q.m9 ? f_q.sh[DATA_W-1:0] : f_q.sh[FR_W-1:1];
    assign bit9_o  = f_q.m9 & f_q.sh[FR_W-1];
    assign ferr_o  = ~maj3(f_q.smp[1], f_q.smp[0], line_i);
    assign mode9_o = f_q.m9;
endmodule

// File: rtl/uart_addr_rx_buf.sv
module uart_addr_rx_buf #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              addr_det_i,
    input  logic              rd_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              bit9_i,
    input  logic              ferr_i,
    input  logic              mode9_i,
    output logic [DATA_W-1:0] data_o,
    output logic              bit9_o,
    output logic              ready_o,
    output logic              ferr_o,
    output logic              ovr_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bit9;
        logic              rdy;
        logic              ferr;
        logic              ovr;
    } buf_t;

    buf_t b_d, b_q;
    logic filtered;
    logic accept;

    always_comb begin
        b_d      = b_q;
        filtered = mode9_i & addr_det_i & ~bit9_i;
        accept   = valid_i & en_i & ~filtered;
        if (rd_i) begin
            b_d.rdy = 1'b0;
        end
        if (!en_i) begin
            b_d.ovr = 1'b0;
        end
        if (accept) begin
            if (b_q.ovr || (b_q.rdy && !rd_i)) begin
                b_d.ovr = 1'b1;
            end else begin
                b_d.data = data_i;
                b_d.bit9 = bit9_i;
                b_d.ferr = ferr_i;
                b_d.rdy  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign data_o  = b_q.data;
    assign bit9_o  = b_q.bit9;
    assign ready_o = b_q.rdy;
    assign ferr_o  = b_q.ferr;
    assign ovr_o   = b_q.ovr;
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
    parameter int unsigned OVS         = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              tick_i,
    input  logic              rx_en_i,
    input  logic              mode9_i,
    input  logic              addr_det_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_bit9_o,
    output logic              rx_ready_o,
    output logic              frame_err_o,
    output logic              overrun_o
);
    logic              line_s;
    logic              line_fall;
    logic              frm_valid;
    logic [DATA_W-1:0] frm_data;
    logic              frm_bit9;
    logic              frm_ferr;
    logic              frm_mode9;

    uart_addr_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_i),
        .line_o (line_s),
        .fall_o (line_fall)
    );

    uart_addr_rx_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (rx_en_i),
        .tick_i  (tick_i),
        .mode9_i (mode9_i),
        .line_i  (line_s),
        .fall_i  (line_fall),
        .valid_o (frm_valid),
        .data_o  (frm_data),
        .bit9_o  (frm_bit9),
        .ferr_o  (frm_ferr),
        .mode9_o (frm_mode9)
    );

    uart_addr_rx_buf #(.DATA_W(DATA_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (rx_en_i),
        .addr_det_i (addr_det_i),
        .rd_i       (rd_i),
        .valid_i    (frm_valid),
        .data_i     (frm_data),
        .bit9_i     (frm_bit9),
        .ferr_i     (frm_ferr),
        .mode9_i    (frm_mode9),
        .data_o     (rx_data_o),
        .bit9_o     (rx_bit9_o),
        .ready_o    (rx_ready_o),
        .ferr_o     (frame_err_o),
        .ovr_o      (overrun_o)
    );
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en_i,
    input logic              addr_det_i,
    input logic              rd_i,
    input logic              frm_valid,
    input logic              frm_bit9,
    input logic              frm_mode9,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              rx_bit9_o,
    input logic              rx_ready_o,
    input logic              overrun_o
);
    // R1: the ready flag only rises after a completed frame
    assert_ready_from_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready_o) |-> $past(frm_valid));

    // R1: an eight-bit frame never shows a ninth bit
    assert_no_bit9_in_8bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_ready_o) && !$past(frm_mode9)) |-> !rx_bit9_o);

    // R3: a filtered data frame leaves the buffer untouched
    assert_filter_keeps_buf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_mode9 && addr_det_i && !frm_bit9)
            |=> ($stable(rx_data_o) && !$rose(rx_ready_o)));

    // R10: a read with no frame arriving empties the buffer
    assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !frm_valid) |=> !rx_ready_o);

    // R11: a latched overrun blocks loading
    assert_overrun_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && rx_en_i) |=> $stable(rx_data_o));

    // R11: dropping the enable clears the overrun
    assert_overrun_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i |=> !overrun_o);

    // R12: no frame completes while reception is off
    assert_idle_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i |-> !frm_valid);
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en_i    (rx_en_i),
    .addr_det_i (addr_det_i),
    .rd_i       (rd_i),
    .frm_valid  (frm_valid),
    .frm_bit9   (frm_bit9),
    .frm_mode9  (frm_mode9),
    .rx_data_o  (rx_data_o),
    .rx_bit9_o  (rx_bit9_o),
    .rx_ready_o (rx_ready_o),
    .overrun_o  (overrun_o)
);

// File: tb/uart_addr_rx_bench.sv
module uart_addr_rx_bench;
    localparam int OVS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b1;
    logic       rx_en = 1'b0;
    logic       mode9 = 1'b0;
    logic       addr_det = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       rx_ready;
    logic       ferr;
    logic       ovr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    uart_addr_rx u_uart_addr_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_i        (rx),
        .tick_i      (tick),
        .rx_en_i     (rx_en),
        .mode9_i     (mode9),
        .addr_det_i  (addr_det),
        .rd_i        (rd),
        .rx_data_o   (rx_data),
        .rx_bit9_o   (rx_bit9),
        .rx_ready_o  (rx_ready),
        .frame_err_o (ferr),
        .overrun_o   (ovr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rx = v;
        repeat (OVS) @(negedge clk);
    endtask

    // nb data bits LSB first; glitch_bit >= 0 inverts one clock at the mid sample
    task automatic send(input logic [8:0] val, input int nb, input logic stop_ok,
                        input int glitch_bit);
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            if (i == glitch_bit) begin
                rx = val[i];
                repeat (9) @(negedge clk);
                rx = ~val[i];
                @(negedge clk);
                rx = val[i];
                repeat (6) @(negedge clk);
            end else begin
                hold_bit(val[i]);
            end
        end
        hold_bit(stop_ok);
        rx = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset ready", 32'(rx_ready), 0);
        check("R1 reset data", 32'(rx_data), 0);
        check("R9 reset ferr", 32'(ferr), 0);
        check("R11 reset ovr", 32'(ovr), 0);
    endtask

    task automatic t_8bit();
        mode9 = 1'b0; addr_det = 1'b0;
        send(9'h0A5, 8, 1'b1, -1);
        check("R1 data", 32'(rx_data), 32'h A5);
        check("R1 ready", 32'(rx_ready), 1);
        check("R1 bit9", 32'(rx_bit9), 0);
        do_read();
        check("R10 ready cleared", 32'(rx_ready), 0);
    endtask

    task automatic t_9bit();
        mode9 = 1'b1; addr_det = 1'b0;
        send(9'h13C, 9, 1'b1, -1);
        check("R2 data", 32'(rx_data), 32'h3C);
        check("R2 bit9 set", 32'(rx_bit9), 1);
        do_read();
        send(9'h055, 9, 1'b1, -1);
        check("R6 data", 32'(rx_data), 32'h55);
        check("R6 bit9 clear", 32'(rx_bit9), 0);
        check("R6 ready", 32'(rx_ready), 1);
        do_read();
    endtask

    task automatic t_addr();
        mode9 = 1'b1; addr_det = 1'b1;
        send(9'h077, 9, 1'b1, -1);
        check("R3 no ready", 32'(rx_ready), 0);
        check("R3 data kept", 32'(rx_data), 32'h55);
        send(9'h1A2, 9, 1'b1, -1);
        check("R4 ready", 32'(rx_ready), 1);
        check("R4 data", 32'(rx_data), 32'hA2);
        check("R4 bit9", 32'(rx_bit9), 1);
        do_read();
        addr_det = 1'b0;
        send(9'h034, 9, 1'b1, -1);
        check("R6 data after select", 32'(rx_data), 32'h34);
        check("R6 ready after select", 32'(rx_ready), 1);
        do_read();
    endtask

    task automatic t_addr8();
        mode9 = 1'b0; addr_det = 1'b1;
        send(9'h012, 8, 1'b1, -1);
        check("R5 ready", 32'(rx_ready), 1);
        check("R5 data", 32'(rx_data), 32'h12);
        do_read();
        addr_det = 1'b0;
    endtask

    task automatic t_start_glitch();
        @(negedge clk);
        rx = 1'b0;
        repeat (4) @(negedge clk);
        rx = 1'b1;
        repeat (40) @(negedge clk);
        check("R7 no frame from glitch", 32'(rx_ready), 0);
        send(9'h081, 8, 1'b1, -1);
        check("R7 recovers", 32'(rx_data), 32'h81);
        do_read();
    endtask

    task automatic t_vote();
        send(9'h00F, 8, 1'b1, 2);
        check("R8 vote data", 32'(rx_data), 32'h0F);
        do_read();
        send(9'h0F0, 8, 1'b1, 6);
        check("R8 vote data high bit", 32'(rx_data), 32'hF0);
        do_read();
    endtask

    task automatic t_ferr();
        send(9'h03C, 8, 1'b0, -1);
        check("R9 ferr set", 32'(ferr), 1);
        check("R9 frame kept", 32'(rx_data), 32'h3C);
        do_read();
        send(9'h0C3, 8, 1'b1, -1);
        check("R9 ferr cleared", 32'(ferr), 0);
        do_read();
    endtask

    task automatic t_overrun();
        send(9'h011, 8, 1'b1, -1);
        send(9'h022, 8, 1'b1, -1);
        check("R11 ovr set", 32'(ovr), 1);
        check("R11 first kept", 32'(rx_data), 32'h11);
        do_read();
        send(9'h033, 8, 1'b1, -1);
        check("R11 blocked ready", 32'(rx_ready), 0);
        check("R11 blocked data", 32'(rx_data), 32'h11);
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);
        check("R11 ovr cleared", 32'(ovr), 0);
        send(9'h044, 8, 1'b1, -1);
        check("R11 resumes", 32'(rx_data), 32'h44);
        do_read();
    endtask

    task automatic t_disabled();
        rx_en = 1'b0;
        send(9'h099, 8, 1'b1, -1);
        check("R12 no ready", 32'(rx_ready), 0);
        check("R12 data kept", 32'(rx_data), 32'h44);
        rx_en = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        t_8bit();
        t_9bit();
        t_addr();
        t_addr8();
        t_start_glitch();
        t_vote();
        t_ferr();
        t_overrun();
        t_disabled();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule